// File: doc/BRIEF.md
# Multi-Plane Display Memory Controller

This block holds the 64-byte image store of one 8x8 LED matrix driver. It divides the store into image planes according to two configuration bits, pixel depth and colour. One plane, the active plane, is read by the refresh logic. The host writes and reads any byte, in any plane, through a byte-wide port. While one image is on display, the host can build the next image in a plane that is not shown.

A plane counter names the active plane. The host can load a pending plane index directly. A timer can also advance the pending index at a programmable interval, wrapping over the planes that the current mode provides. The pending index is copied to the displayed index only when the refresh logic signals a frame boundary, so one refresh frame never mixes two planes.

The refresh side gives a colour select and a byte index inside that colour. The block turns these into a memory address that depends on the mode and on the active plane. The timer unit and the second scaler are parameters, so the same logic gives intervals from 1/63 s up to 63 s.

Top module: `plane_mem_ctrl`

## Requirements
- R1: After reset, plane_idx is 0 and automatic switching is off (interval 0).
- R2: When host_we is high, the byte at linear address host_addr (0 to 63) takes host_wdata at the clock edge. host_rdata always shows the byte at host_addr.
- R3: Mono, 1 bit per pixel (cfg_depth2=0, cfg_color=0): there are four planes of 16 bytes. ref_data is the byte at 16*plane + ref_byte[3:0], and ref_green is ignored.
- R4: Red/green, 1 bit per pixel (cfg_depth2=0, cfg_color=1): ref_data is the byte at 16*plane + 8*ref_green + ref_byte[2:0]. Red occupies offsets 0 to 7 of the plane and green occupies offsets 8 to 15.
- R5: Mono, 2 bits per pixel (cfg_depth2=1, cfg_color=0): there are two planes of 32 bytes. ref_data is the byte at 32*plane + ref_byte[4:0], and ref_green is ignored.
- R6: Red/green, 2 bits per pixel (cfg_depth2=1, cfg_color=1): ref_data is the byte at 32*plane + 16*ref_byte[3] + 8*ref_green + ref_byte[2:0]. Each colour therefore sits in two separate groups of 8 bytes.
- R7: A clock edge with ctl_wr high loads the pending plane with ctl_plane, modulo the plane count of the mode. The same edge loads the interval and unit fields and restarts the timer.
- R8: plane_idx changes only at a clock edge where frame_start is high, and then takes the pending plane. In 2-bit modes, plane_idx bit 1 reads as 0.
- R9: With interval P (1 to 63), the pending plane advances every P*UNIT_CYCLES cycles when ctl_secs was 0. When ctl_secs was 1, it advances every P*UNIT_CYCLES*SEC_UNITS cycles. The first advance comes that many cycles after the ctl_wr edge.
- R10: An automatic advance wraps modulo 4 in 1-bit modes and modulo 2 in 2-bit modes.
- R11: An interval of 0 disables automatic switching, and the pending plane then holds.
- R12: A host write to the active plane shows on ref_data from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth2 | input | 1 | 1 = 2 bits per pixel (two planes), 0 = 1 bit per pixel (four planes) |
| cfg_color | input | 1 | 1 = red/green layout, 0 = mono |
| ctl_wr | input | 1 | Load strobe for the plane-counter control fields |
| ctl_plane | input | 2 | Plane index loaded directly into the pending plane |
| ctl_period | input | 6 | Auto-switch interval in units, 0 = off |
| ctl_secs | input | 1 | Unit select: 0 = 1/63 s, 1 = 1 s |
| frame_start | input | 1 | Frame boundary from the refresh logic |
| host_we | input | 1 | Host write enable |
| host_addr | input | 6 | Host linear byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data at host_addr |
| ref_green | input | 1 | Refresh colour select (1 = green) |
| ref_byte | input | 5 | Refresh byte index within the colour |
| ref_data | output | 8 | Byte of the active plane for the refresh request |
| plane_idx | output | 2 | Displayed plane index |

## Verification
The bench builds the block with UNIT_CYCLES=4 and SEC_UNITS=3. With these values a full interval in either unit lasts only tens of cycles. This lets the bench check exact advance times, wrapping over four and over two planes, and the disabled case within a short run. The small store also lets the bench sweep every mode, every plane index, both colours and every byte index against an address model computed in the bench.

// File: rtl/plane_mem_ctrl.sv
module plane_mem_ctrl #(
  parameter int UNIT_CYCLES = 317460,
  parameter int SEC_UNITS   = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_depth2,
  input  logic       cfg_color,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_plane,
  input  logic [5:0] ctl_period,
  input  logic       ctl_secs,
  input  logic       frame_start,
  input  logic       host_we,
  input  logic [5:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       ref_green,
  input  logic [4:0] ref_byte,
  output logic [7:0] ref_data,
  output logic [1:0] plane_idx
);
  localparam int PW = $clog2(UNIT_CYCLES > 1 ? UNIT_CYCLES : 2);
  localparam int SW = $clog2(SEC_UNITS > 1 ? SEC_UNITS : 2);

  logic [7:0]    mem [64];
  logic [PW-1:0] pre;
  logic [SW-1:0] sec;
  logic [5:0]    icnt, period_q;
  logic          secs_q;
  logic [1:0]    pend, cur, nxt, eff;
  logic          tick, stick, step, adv;
  logic [4:0]    off;
  logic [5:0]    ref_addr;

  assign tick  = pre == PW'(UNIT_CYCLES - 1);
  assign stick = tick && (sec == SW'(SEC_UNITS - 1));
  assign step  = secs_q ? stick : tick;
  assign adv   = (period_q != 6'd0) && step && (icnt == period_q - 6'd1);
  assign nxt   = cfg_depth2 ? {1'b0, ~pend[0]} : pend + 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0; sec <= '0; icnt <= '0; period_q <= '0; secs_q <= 1'b0; pend <= '0;
    end else if (ctl_wr) begin
      pre <= '0; sec <= '0; icnt <= '0;
      period_q <= ctl_period;
      secs_q   <= ctl_secs;
      pend     <= cfg_depth2 ? {1'b0, ctl_plane[0]} : ctl_plane;
    end else begin
      pre <= tick ? '0 : pre + PW'(1);
      if (tick) sec <= stick ? '0 : sec + SW'(1);
      if (step && period_q != 6'd0) icnt <= adv ? 6'd0 : icnt + 6'd1;
      if (adv) pend <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else if (frame_start) cur <= pend;
  end

  assign eff       = cfg_depth2 ? {1'b0, cur[0]} : cur;
  assign plane_idx = eff;

  always_ff @(posedge clk)
    if (host_we) mem[host_addr] <= host_wdata;

  always_comb begin
    case ({cfg_depth2, cfg_color})
      2'b00:   off = {1'b0, ref_byte[3:0]};
      2'b01:   off = {1'b0, ref_green, ref_byte[2:0]};
      2'b10:   off = ref_byte;
      default: off = {ref_byte[3], ref_green, ref_byte[2:0]};
    endcase
  end

  assign ref_addr   = cfg_depth2 ? {eff[0], off} : {eff, off[3:0]};
  assign ref_data   = mem[ref_addr];
  assign host_rdata = mem[host_addr];

  assert_plane_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur));
  assert_auto_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == 6'd0 && !ctl_wr) |=> $stable(pend));
  assert_direct_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> pend[0] == $past(ctl_plane[0]));
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == 6'd0) || (icnt < period_q));
  assert_wrap_two_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ctl_wr && cfg_depth2) |=> pend[1] == 1'b0);
endmodule

// File: tb/sim_plane_mem_ctrl.sv
`timescale 1ns/1ps
module sim_plane_mem_ctrl;
  localparam int U = 4, S = 3;
  logic clk = 0, rst_n = 0, cfg_depth2 = 0, cfg_color = 0, ctl_wr = 0, ctl_secs = 0;
  logic frame_start = 0, host_we = 0, ref_green = 0;
  logic [1:0] ctl_plane = 0, plane_idx;
  logic [5:0] ctl_period = 0, host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata, ref_data;
  logic [4:0] ref_byte = 0;
  logic [7:0] model [64];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  plane_mem_ctrl #(.UNIT_CYCLES(U), .SEC_UNITS(S)) u0 (
    .clk, .rst_n, .cfg_depth2, .cfg_color, .ctl_wr, .ctl_plane, .ctl_period, .ctl_secs,
    .frame_start, .host_we, .host_addr, .host_wdata, .host_rdata, .ref_green, .ref_byte,
    .ref_data, .plane_idx);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic int map_addr(bit d, bit c, int p, bit g, int b);
    int off;
    case ({d, c})
      2'b00: off = b % 16;
      2'b01: off = g * 8 + b % 8;
      2'b10: off = b % 32;
      default: off = ((b / 8) % 2) * 16 + g * 8 + b % 8;
    endcase
    return d ? (p % 2) * 32 + off : p * 16 + off;
  endfunction

  task automatic hwrite(int a, int v);
    @(negedge clk); host_we = 1; host_addr = 6'(a); host_wdata = 8'(v);
    @(negedge clk); host_we = 0;
    model[a] = 8'(v);
  endtask

  task automatic ctl(int p, int per, bit secs);
    @(negedge clk); ctl_wr = 1; ctl_plane = 2'(p); ctl_period = 6'(per); ctl_secs = secs;
    @(posedge clk);
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic set_plane(int p);
    ctl(p, 0, 0);
    frame_start = 1;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic auto_run(bit d, bit secs, int per, int start, int n, string req);
    int t, exp;
    cfg_depth2 = d; frame_start = 1;
    t = per * U * (secs ? S : 1);
    exp = d ? start % 2 : start;
    @(negedge clk); ctl_wr = 1; ctl_plane = 2'(start); ctl_period = 6'(per); ctl_secs = secs;
    @(posedge clk);
    @(negedge clk); ctl_wr = 0;
    for (int k = 1; k <= n; k++) begin
      repeat (k == 1 ? t - 1 : t - 1) @(posedge clk);
      if (k == 1) @(posedge clk);
      @(negedge clk);
      chk({req, " before step"}, plane_idx, exp);
      exp = d ? (exp + 1) % 2 : (exp + 1) % 4;
      @(negedge clk);
      chk({req, " after step"}, plane_idx, exp);
    end
    frame_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset plane", plane_idx, 0);
    frame_start = 1;
    repeat (40) @(negedge clk);
    chk("R1 auto off after reset", plane_idx, 0);
    frame_start = 0;

    for (int a = 0; a < 64; a++) hwrite(a, a * 7 + 3);
    for (int a = 0; a < 64; a++) begin
      host_addr = 6'(a); #1;
      chk("R2 host read", host_rdata, model[a]);
    end

    for (int m = 0; m < 4; m++) begin
      cfg_depth2 = m[1]; cfg_color = m[0];
      for (int p = 0; p < 4; p++) begin
        set_plane(p);
        chk("R7 direct plane", plane_idx, m[1] ? p % 2 : p);
        for (int g = 0; g < 2; g++)
          for (int b = 0; b < (m == 1 ? 8 : (m == 2 ? 32 : 16)); b++) begin
            ref_green = g[0]; ref_byte = 5'(b); #1;
            chk(m == 0 ? "R3 mono1 map" : m == 1 ? "R4 rg1 map" : m == 2 ? "R5 mono2 map" : "R6 rg2 map",
                ref_data, model[map_addr(m[1], m[0], p, g[0], b)]);
          end
      end
    end

    cfg_depth2 = 0; cfg_color = 1;
    set_plane(1);
    ref_green = 1; ref_byte = 5'd3;
    hwrite(map_addr(0, 1, 1, 1, 3), 8'h5C);
    chk("R12 active write visible", ref_data, 8'h5C);

    cfg_color = 0;
    set_plane(1);
    ctl(2, 0, 0);
    repeat (5) @(negedge clk);
    chk("R8 hold without frame_start", plane_idx, 1);
    frame_start = 1; @(negedge clk); frame_start = 0;
    chk("R8 change at frame_start", plane_idx, 2);

    auto_run(0, 0, 3, 1, 5, "R9 R10 units wrap4");
    auto_run(0, 1, 2, 2, 3, "R9 seconds unit");
    auto_run(1, 0, 1, 1, 3, "R10 wrap2");

    cfg_depth2 = 0;
    set_plane(3);
    frame_start = 1;
    repeat (100) @(negedge clk);
    chk("R11 interval zero holds", plane_idx, 3);
    frame_start = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule